// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block turns a 36-segment by 4-common display image into per-pin drive-level codes for a quarter-duty multiplexed LCD. Each output pin gets a 2-bit code that names one of four voltage points: 0 is the ground rail, 1 is the lower bias tap, 2 is the upper bias tap and 3 is the opposite rail. A separate analog stage turns each code into a voltage. With half bias, only codes 0, 1 and 3 appear, and code 1 stands for the midpoint.

A single system tick enable (`tick_en`) drives two dividers. The first steps the scan through eight half-slots per frame, two for each common, at one of four frame rates. The second gates the whole image on and off at one of three blink rates. The display image arrives as a flat vector of 4-bit columns, one column per segment. The sequencer needs no generated clock. Software settings arrive as plain level inputs: bias, inversion style, display enable, blink rate, frame rate and an all-pixels override.

Top module: `lcd_wave_seq`

## Requirements
- R1: While `rst` is high, and from the first clock after `disp_en` is sampled low, every common and segment code is 0. The scan and blink counters restart when the display is re-enabled.
- R2: A frame has 8 steps, numbered 0 to 7 from the reset. Step k selects common k/2, so the commons are scanned 0 to 3 with each held for two steps. Exactly one common sits on a rail (code 0 or 3) at any time.
- R3: The step counter advances only on clocks with `tick_en` high. With `tick_en` low the codes hold.
- R4: One step lasts D ticks, where D = floor(STEP_TICKS*80/F) and F is 80, 71, 64 or 53 for `rate_sel` = 0, 1, 2 or 3. The outputs are registered, so step k is visible from tick k*D+1 to tick (k+1)*D.
- R5: Segment s uses bits [4s+3:4s] of `ram_bits`. Bit 4s+3 drives it while common 0 is selected, and bits 4s+2, 4s+1 and 4s+0 drive it for commons 1, 2 and 3. A 1 means the segment is on.
- R6: Third bias (`bias_half`=0). With polarity 0, the selected common is 3, the other commons are 1, an on segment is 0 and an off segment is 2. With polarity 1, these become 0, 2, 3 and 1.
- R7: Half bias (`bias_half`=1). With polarity 0, the selected common is 3, the other commons are 1, an on segment is 0 and an off segment is 3. With polarity 1, these become 0, 1, 3 and 0. Code 2 never appears.
- R8: With `inv_frame`=0, the polarity equals the step's low bit, so every common slot has a polarity-0 half followed by a polarity-1 half.
- R9: With `inv_frame`=1, the polarity is constant within a frame. It is 0 in even frames and 1 in odd frames, counted from the reset.
- R10: With `blink_sel` = 3, 2 or 1, the image is visible for BLINK_TICKS, 2*BLINK_TICKS or 4*BLINK_TICKS ticks, then blank for the same count, and the pattern repeats. With `blink_sel`=0 the image is never blanked.
- R11: With `pix_mode` = 2'b10, every segment is on. With 2'b01 or 2'b11, every segment is off. With 2'b00, the segments follow `ram_bits`, and setting 2'b00 again restores the image.
- R12: During a blank blink phase every segment is driven as off, including in all-on mode. The commons keep scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | System tick enable that drives both dividers |
| disp_en | input | 1 | Display enable; low forces all codes to ground |
| bias_half | input | 1 | 1 selects half bias, 0 selects third bias |
| inv_frame | input | 1 | 1 selects per-frame inversion, 0 selects per-slot inversion |
| blink_sel | input | 2 | 0 is off; 1, 2 and 3 are the slow, medium and fast blink |
| rate_sel | input | 2 | Frame rate select: 80, 71, 64 or 53 relative |
| pix_mode | input | 2 | 00 normal, 10 all on, 01 or 11 all off |
| ram_bits | input | 144 | Display image, one 4-bit column per segment |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 72 | Segment level codes, 2 bits per segment |

## Verification
The assertions assume that the settings inputs stay constant between resets, except for `pix_mode` and `disp_en`. The blink and bias checks compare registered outputs against settings sampled one clock earlier. The bench follows this rule: each task sets all configuration inputs while `rst` is high, and only the override and enable inputs change during a run. The tick input is either held constant or toggled on a fixed every-other-clock pattern. This lets the bench work out in advance which tick each step and blink phase starts on.

// File: rtl/lcd_wave_pkg.sv
package lcd_wave_pkg;

    // Scan is fixed at quarter duty.
    localparam int unsigned NUM_COM = 4;
    localparam int unsigned SLOT_W  = 2;

    // Drive level codes, from the ground rail to the opposite rail.
    typedef enum logic [1:0] {
        LVL_GND   = 2'd0,
        LVL_LOTAP = 2'd1,
        LVL_HITAP = 2'd2,
        LVL_RAIL  = 2'd3
    } lvl_e;

    // All-pixels override codes.
    localparam logic [1:0] PIX_NORMAL = 2'b00;
    localparam logic [1:0] PIX_ALL_ON = 2'b10;

    // Scan position: common slot, half within the slot, frame parity.
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              half;
        logic              odd_frame;
    } scan_t;

    // Ticks per scan step for a rate select, scaled from the fastest rate.
    function automatic int unsigned step_div(input logic [1:0] sel, input int unsigned base);
        case (sel)
            2'd0:    return base;
            2'd1:    return (base * 80) / 71;
            2'd2:    return (base * 80) / 64;
            default: return (base * 80) / 53;
        endcase
    endfunction

    function automatic lvl_e com_level(input logic sel, input logic pol, input logic half_bias);
        if (sel)
            return pol ? LVL_GND : LVL_RAIL;
        else if (!pol || half_bias)
            return LVL_LOTAP;
        else
            return LVL_HITAP;
    endfunction

    function automatic lvl_e seg_level(input logic on, input logic pol, input logic half_bias);
        if (!pol)
            return on ? LVL_GND : (half_bias ? LVL_RAIL : LVL_HITAP);
        else
            return on ? LVL_RAIL : (half_bias ? LVL_GND : LVL_LOTAP);
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_wave_pkg::*;
#(
    parameter int unsigned STEP_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        tick_en,
    input  logic [1:0]  rate_sel,
    output scan_t       scan
);
    localparam int unsigned DIVW = $clog2((STEP_TICKS * 80) / 53 + 1);

    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] lim;

    assign lim = DIVW'(step_div(rate_sel, STEP_TICKS) - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            scan <= '0;
        end else if (tick_en) begin
            if (cnt >= lim) begin
                cnt                    <= '0;
                {scan.slot, scan.half} <= {scan.slot, scan.half} + 3'd1;
                if ({scan.slot, scan.half} == 3'b111)
                    scan.odd_frame <= ~scan.odd_frame;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: the scan position is frozen on clocks without a tick
    p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick_en) |=> $stable(scan));

endmodule

// File: rtl/lcd_blink_timer.sv
module lcd_blink_timer #(
    parameter int unsigned BLINK_TICKS = 10240
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick_en,
    input  logic [1:0] blink_sel,
    output logic       blank
);
    localparam int unsigned BW = $clog2(BLINK_TICKS * 4 + 1);

    logic [BW-1:0] cnt;
    logic [BW-1:0] lim;

    // Slower modes hold each phase for a longer run of ticks.
    always_comb begin
        case (blink_sel)
            2'd3:    lim = BW'(BLINK_TICKS - 1);
            2'd2:    lim = BW'(2 * BLINK_TICKS - 1);
            default: lim = BW'(4 * BLINK_TICKS - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run || blink_sel == 2'd0) begin
            cnt   <= '0;
            blank <= 1'b0;
        end else if (tick_en) begin
            if (cnt >= lim) begin
                cnt   <= '0;
                blank <= ~blank;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: blink off never darkens the image
    p_no_blank_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        (blink_sel == 2'd0) |=> !blank);

endmodule

// File: rtl/lcd_pin_driver.sv
module lcd_pin_driver
    import lcd_wave_pkg::*;
#(
    parameter int unsigned NUM_SEG = 36
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       disp_en,
    input  logic                       bias_half,
    input  logic                       inv_frame,
    input  logic [1:0]                 pix_mode,
    input  logic                       blank,
    input  scan_t                      scan,
    input  logic [NUM_SEG*NUM_COM-1:0] ram_bits,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);
    logic                    pol;
    logic [2*NUM_COM-1:0]    com_nx;
    logic [2*NUM_SEG-1:0]    seg_nx;

    // Per-slot inversion follows the half bit; per-frame follows frame parity.
    assign pol = inv_frame ? scan.odd_frame : scan.half;

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        assign com_nx[c*2 +: 2] = com_level(scan.slot == SLOT_W'(c), pol, bias_half);
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [NUM_COM-1:0] col;
        logic               on;
        assign col = ram_bits[s*NUM_COM +: NUM_COM];
        always_comb begin
            case (pix_mode)
                PIX_NORMAL: on = col[SLOT_W'(NUM_COM - 1) - scan.slot] && !blank;
                PIX_ALL_ON: on = !blank;
                default:    on = 1'b0;
            endcase
        end
        assign seg_nx[s*2 +: 2] = seg_level(on, pol, bias_half);
    end

    always_ff @(posedge clk) begin
        if (rst || !disp_en) begin
            com_lvl <= '0;
            seg_lvl <= '0;
        end else begin
            com_lvl <= com_nx;
            seg_lvl <= seg_nx;
        end
    end

    // Checking state: settings that the current outputs were built from.
    logic               en_q;
    logic               hb_q;
    logic [NUM_COM-1:0] com_at_rail;
    logic               any_hitap;

    always_ff @(posedge clk) begin
        en_q <= !rst && disp_en;
        hb_q <= bias_half;
    end

    for (genvar c = 0; c < NUM_COM; c++) begin : g_rail
        assign com_at_rail[c] = (com_lvl[c*2 +: 2] == LVL_GND) || (com_lvl[c*2 +: 2] == LVL_RAIL);
    end

    always_comb begin
        any_hitap = 1'b0;
        for (int i = 0; i < NUM_COM; i++)
            if (com_lvl[i*2 +: 2] == LVL_HITAP) any_hitap = 1'b1;
        for (int i = 0; i < NUM_SEG; i++)
            if (seg_lvl[i*2 +: 2] == LVL_HITAP) any_hitap = 1'b1;
    end

    // R2: one and only one common is selected while driving
    p_single_select_r2: assert property (@(posedge clk) disable iff (rst)
        en_q |-> $onehot(com_at_rail));

    // R7: half bias never uses the upper tap
    p_half_no_upper_tap_r7: assert property (@(posedge clk) disable iff (rst)
        (en_q && hb_q) |-> !any_hitap);

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
    import lcd_wave_pkg::*;
#(
    parameter int unsigned NUM_SEG     = 36,
    parameter int unsigned STEP_TICKS  = 64,
    parameter int unsigned BLINK_TICKS = 10240
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick_en,
    input  logic                       disp_en,
    input  logic                       bias_half,
    input  logic                       inv_frame,
    input  logic [1:0]                 blink_sel,
    input  logic [1:0]                 rate_sel,
    input  logic [1:0]                 pix_mode,
    input  logic [NUM_SEG*NUM_COM-1:0] ram_bits,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);
    scan_t scan;
    logic  blank;

    lcd_scan_timer #(.STEP_TICKS(STEP_TICKS)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .run      (disp_en),
        .tick_en  (tick_en),
        .rate_sel (rate_sel),
        .scan     (scan)
    );

    lcd_blink_timer #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
        .clk       (clk),
        .rst       (rst),
        .run       (disp_en),
        .tick_en   (tick_en),
        .blink_sel (blink_sel),
        .blank     (blank)
    );

    lcd_pin_driver #(.NUM_SEG(NUM_SEG)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .disp_en   (disp_en),
        .bias_half (bias_half),
        .inv_frame (inv_frame),
        .pix_mode  (pix_mode),
        .blank     (blank),
        .scan      (scan),
        .ram_bits  (ram_bits),
        .com_lvl   (com_lvl),
        .seg_lvl   (seg_lvl)
    );

    // R1: a disabled display parks every pin at ground
    p_dark_when_off_r1: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> (com_lvl == '0 && seg_lvl == '0));

endmodule

// File: tb/lcd_wave_seq_bench.sv
module lcd_wave_seq_bench;
    localparam int NSEG = 36;
    localparam int BASE = 8;
    localparam int BLNK = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en;
    logic              disp_en = 1'b1;
    logic              bias_half = 1'b0;
    logic              inv_frame = 1'b0;
    logic [1:0]        blink_sel = 2'd0;
    logic [1:0]        rate_sel = 2'd0;
    logic [1:0]        pix_mode = 2'b00;
    logic [NSEG*4-1:0] ram_bits = '0;
    logic [7:0]        com_lvl;
    logic [2*NSEG-1:0] seg_lvl;

    int edges = 0;
    int tick_mode = 0;  // 0 always, 1 every other clock, 2 never
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) edges <= rst ? 0 : edges + 1;

    always_comb begin
        case (tick_mode)
            0:       tick_en = 1'b1;
            1:       tick_en = (edges % 2 == 0);
            default: tick_en = 1'b0;
        endcase
    end

    lcd_wave_seq #(.NUM_SEG(NSEG), .STEP_TICKS(BASE), .BLINK_TICKS(BLNK)) u_lcd_wave_seq (
        .clk(clk), .rst(rst), .tick_en(tick_en), .disp_en(disp_en),
        .bias_half(bias_half), .inv_frame(inv_frame), .blink_sel(blink_sel),
        .rate_sel(rate_sel), .pix_mode(pix_mode), .ram_bits(ram_bits),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // Expected codes, taken from the requirement tables.
    function automatic logic [1:0] e_com(int c, int k);
        int slot = (k % 8) / 2;
        int pol  = inv_frame ? (k / 8) % 2 : k % 2;
        if (c == slot) return pol ? 2'd0 : 2'd3;
        if (pol == 0 || bias_half) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [1:0] e_seg(int s, int k, bit blank_ph);
        int  slot = (k % 8) / 2;
        int  pol  = inv_frame ? (k / 8) % 2 : k % 2;
        bit  on;
        if (pix_mode == 2'b00)      on = ram_bits[s*4 + 3 - slot] && !blank_ph;
        else if (pix_mode == 2'b10) on = !blank_ph;
        else                        on = 1'b0;
        if (pol == 0) return on ? 2'd0 : (bias_half ? 2'd3 : 2'd2);
        return on ? 2'd3 : (bias_half ? 2'd0 : 2'd1);
    endfunction

    task automatic restart();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic go_to(int t);
        while (edges < t) @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] ec, logic [2*NSEG-1:0] es);
        n_chk++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            n_bad++;
            $display("FAIL %s at edge %0d: com=%h seg=%h expected com=%h seg=%h",
                     req, edges, com_lvl, seg_lvl, ec, es);
        end
    endtask

    // Sample the middle of step k (step length d ticks, tick every clock).
    task automatic check_step(string req, int k, int d, bit blank_ph);
        logic [7:0]        ec;
        logic [2*NSEG-1:0] es;
        go_to(k * d + d / 2);
        for (int c = 0; c < 4; c++) ec[c*2 +: 2] = e_com(c, k);
        for (int s = 0; s < NSEG; s++) es[s*2 +: 2] = e_seg(s, k, blank_ph);
        check(req, ec, es);
    endtask

    task automatic fill_ram(int seed);
        for (int s = 0; s < NSEG; s++) ram_bits[s*4 +: 4] = 4'((s * 7 + seed) % 16);
    endtask

    task automatic t_reset_dark();
        fill_ram(3);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", '0, '0);
        restart();
        go_to(20);
        disp_en = 1'b0;
        go_to(22);
        check("R1 disabled", '0, '0);
        disp_en = 1'b1;
    endtask

    task automatic t_third_slot_inv();
        bias_half = 1'b0; inv_frame = 1'b0; fill_ram(5);
        restart();
        for (int k = 0; k < 16; k++) check_step("R2 R5 R6 R8 third bias per-slot", k, BASE, 1'b0);
    endtask

    task automatic t_half_bias();
        bias_half = 1'b1; inv_frame = 1'b0; fill_ram(11);
        restart();
        for (int k = 0; k < 8; k++) check_step("R7 half bias", k, BASE, 1'b0);
        bias_half = 1'b0;
    endtask

    task automatic t_frame_inv();
        inv_frame = 1'b1; bias_half = 1'b0; fill_ram(1);
        restart();
        for (int k = 0; k < 24; k += 3) check_step("R9 per-frame third", k, BASE, 1'b0);
        bias_half = 1'b1;
        restart();
        for (int k = 4; k < 20; k += 5) check_step("R9 per-frame half", k, BASE, 1'b0);
        inv_frame = 1'b0; bias_half = 1'b0;
    endtask

    task automatic t_rates();
        logic [7:0] c0, c1;
        logic [2*NSEG-1:0] s0, s1;
        fill_ram(9);
        rate_sel = 2'd3;
        restart();
        for (int c = 0; c < 4; c++) begin c0[c*2+:2] = e_com(c, 0); c1[c*2+:2] = e_com(c, 1); end
        for (int s = 0; s < NSEG; s++) begin s0[s*2+:2] = e_seg(s, 0, 0); s1[s*2+:2] = e_seg(s, 1, 0); end
        go_to(12);
        check("R4 rate 3 last tick of step 0", c0, s0);
        go_to(13);
        check("R4 rate 3 first tick of step 1", c1, s1);
        check_step("R4 rate 3 step 5", 5, 12, 1'b0);
        rate_sel = 2'd1;
        restart();
        check_step("R4 rate 1 step 3", 3, 9, 1'b0);
        rate_sel = 2'd2;
        restart();
        check_step("R4 rate 2 step 6", 6, 10, 1'b0);
        rate_sel = 2'd0;
    endtask

    task automatic t_tick_gate();
        logic [7:0] ec;
        logic [2*NSEG-1:0] es;
        fill_ram(4);
        tick_mode = 2;
        restart();
        for (int c = 0; c < 4; c++) ec[c*2+:2] = e_com(c, 0);
        for (int s = 0; s < NSEG; s++) es[s*2+:2] = e_seg(s, 0, 0);
        go_to(60);
        check("R3 no tick holds step 0", ec, es);
        tick_mode = 1;
        restart();
        for (int c = 0; c < 4; c++) ec[c*2+:2] = e_com(c, 3);
        for (int s = 0; s < NSEG; s++) es[s*2+:2] = e_seg(s, 3, 0);
        go_to(3 * 16 + 8);
        check("R3 half-rate tick step 3", ec, es);
        tick_mode = 0;
    endtask

    task automatic t_blink();
        fill_ram(6);
        blink_sel = 2'd3;
        restart();
        check_step("R10 fast visible", 2, BASE, 1'b0);
        check_step("R10 R12 fast blank", 10, BASE, 1'b1);
        check_step("R10 fast visible again", 18, BASE, 1'b0);
        blink_sel = 2'd2;
        restart();
        check_step("R10 medium visible", 12, BASE, 1'b0);
        check_step("R10 medium blank", 20, BASE, 1'b1);
        blink_sel = 2'd1;
        restart();
        check_step("R10 slow visible", 28, BASE, 1'b0);
        check_step("R10 slow blank", 36, BASE, 1'b1);
        blink_sel = 2'd0;
        restart();
        check_step("R10 blink off visible", 36, BASE, 1'b0);
        pix_mode = 2'b10; blink_sel = 2'd3;
        restart();
        check_step("R11 all on visible", 3, BASE, 1'b0);
        check_step("R12 all on blanked", 13, BASE, 1'b1);
        pix_mode = 2'b00; blink_sel = 2'd0;
    endtask

    task automatic t_override();
        fill_ram(13);
        pix_mode = 2'b01;
        restart();
        check_step("R11 mode 01 all off", 1, BASE, 1'b0);
        pix_mode = 2'b11;
        check_step("R11 mode 11 all off", 4, BASE, 1'b0);
        pix_mode = 2'b10;
        check_step("R11 mode 10 all on", 7, BASE, 1'b0);
        pix_mode = 2'b00;
        check_step("R11 normal restored", 10, BASE, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset_dark();
        t_third_slot_inv();
        t_half_bias();
        t_frame_inv();
        t_rates();
        t_tick_gate();
        t_blink();
        t_override();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule